// File: doc/BRIEF.md
# System Control and Reset-Cause Registers

This block holds the chip-level mode settings and the reset-cause history for a processor core. It sits on a simple synchronous register bus: address, write enable and write data are sampled on the rising clock edge, and read data is a combinational function of the address. Offset 0 is the control register and offset 1 is the reset-cause register. All other offsets are unmapped.

The control register gates the core's stop and wait requests. Each gate takes a two-bit code. Code 00 lets the request through. Code 01 blocks the request and can be rewritten. Code 10 or 11 blocks the request and freezes the code until the next reset. The control register also:

- forces the debug clock on,
- raises a one-cycle software reset request,
- reflects the live boot-mode pin.

On the first clock edge after any reset, the block latches the role of the upper four address lines from the boot-mode and external-boot pins.

The reset-cause register records software, watchdog, external and power-on resets. `rst_ni` is the power-on reset and clears everything. `sys_rst_ni` is a system reset: it clears the control state but leaves the cause history intact. Software clears cause bits by writing 1 to them.

Top module: `sysctl_regs`

## Requirements
- R1: After power-on reset, the control register reads with bits 5:0 all zero and bit 6 equal to the boot-mode pin. The cause register reads 0x0004, meaning only the power-on bit (bit 2) is set.
- R2: The stop-disable field is control bits 3:2. With code 00, `stop_en_o` follows `stop_req_i`. With any other code, `stop_en_o` is 0.
- R3: Code 10 or 11 in a disable field freezes that field until a reset: writes to the field are ignored. Writes to the other control fields still take effect in the same write.
- R4: The wait-disable field is control bits 1:0. It uses the same codes and locking as R2 and R3, and acts on `wait_req_i` and `wait_en_o`.
- R5: Control bit 4 always reads 0. Writing 1 to it drives `sw_rst_req_o` high for the single cycle after the write edge, and sets cause bit 5 at that edge.
- R6: Control bit 6 reads the current, unregistered level of `boot_mode_i`.
- R7: On the first clock edge after either reset is released, `addr_hi_addr_o` takes the value `boot_mode_i` AND `ext_boot_i`. It then holds that value until the next reset.
- R8: Control bit 5 forces `dbg_clk_en_o` to 1. When bit 5 is 0, `dbg_clk_en_o` follows `tap_en_i`.
- R9: `wdog_rst_evt_i` sets cause bit 4 and `ext_rst_evt_i` sets cause bit 3, each at the sampling edge. A system reset never clears cause bits.
- R10: Writing to offset 1 clears each cause bit whose write-data bit is 1. Bits written as 0 are unchanged. A set and a clear of the same bit in one cycle leaves the bit set.
- R11: Unmapped offsets read 0, and writes to them change nothing. Cause-register bits 15:6 and 1:0 read 0.
- R12: `sys_rst_ni` low returns the control fields to 0, including any locked codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_ni | input | 1 | System reset, active low, asynchronous; clears control state only |
| addr_i | input | ADDR_W | Register offset |
| we_i | input | 1 | Write enable |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, combinational from `addr_i` |
| boot_mode_i | input | 1 | Boot-mode pin |
| ext_boot_i | input | 1 | External-boot strap |
| tap_en_i | input | 1 | Core test access port enabled |
| stop_req_i | input | 1 | Core stop request |
| wait_req_i | input | 1 | Core wait request |
| wdog_rst_evt_i | input | 1 | Watchdog reset cause pulse |
| ext_rst_evt_i | input | 1 | External reset cause pulse |
| stop_en_o | output | 1 | Stop entry granted |
| wait_en_o | output | 1 | Wait entry granted |
| dbg_clk_en_o | output | 1 | Debug clock enable |
| sw_rst_req_o | output | 1 | Software reset request pulse |
| addr_hi_addr_o | output | 1 | Upper address lines default to address use |

## Verification
The results arrive at different times:

- Read data and the stop, wait and debug-clock gates are combinational, so they are due in the same cycle their inputs settle.
- Every register write, cause event and reset release becomes visible one edge later.
- The software reset request is high only during the cycle that follows its write edge.
- The address-line role appears after the first edge following reset release.

Every stimulus is applied just after a falling edge. Its expected value is queued at the same time, and the monitor samples one time unit later. As a result, each sample falls after exactly the edges that R5, R7, R9 and R10 count, and never at a rising edge.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int CTRL_OFS = 0;
  localparam int STS_OFS  = 1;

  localparam int BOOT_BIT = 6;
  localparam int DBG_BIT  = 5;
  localparam int SWR_BIT  = 4;
  localparam int STOP_LSB = 2;
  localparam int WAIT_LSB = 0;

  localparam int STS_LSB  = 2;
  localparam int STS_N    = 4;

  typedef enum logic [1:0] {
    DIS_OFF   = 2'b00,
    DIS_SOFT  = 2'b01,
    DIS_LOCK  = 2'b10,
    DIS_LOCKX = 2'b11
  } dis_code_e;

  // cause register order, msb first: sw, wdog, ext, por
  typedef struct packed {
    logic sw;
    logic wd;
    logic ext;
    logic por;
  } rst_cause_t;
endpackage

// File: rtl/sysctl_dis_field.sv
module sysctl_dis_field
  import sysctl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [1:0] wcode_i,
  input  logic       req_i,
  output logic [1:0] code_o,
  output logic       grant_o
);
  logic [1:0] code_q;
  logic       locked;

  assign locked = code_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                code_q <= DIS_OFF;
    else if (wr_i && !locked)   code_q <= wcode_i;
  end

  assign code_o  = code_q;
  assign grant_o = req_i && (code_q == DIS_OFF);
endmodule

// File: rtl/sysctl_rst_status.sv
module sysctl_rst_status #(
  parameter int          N       = 4,
  parameter logic [N-1:0] POR_VAL = N'(1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] sts_o
);
  logic [N-1:0] sts_q;

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= POR_VAL;
    else         sts_q <= (sts_q & ~clr_i) | set_i;
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sys_rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              boot_mode_i,
  input  logic              ext_boot_i,
  input  logic              tap_en_i,
  input  logic              stop_req_i,
  input  logic              wait_req_i,
  input  logic              wdog_rst_evt_i,
  input  logic              ext_rst_evt_i,
  output logic              stop_en_o,
  output logic              wait_en_o,
  output logic              dbg_clk_en_o,
  output logic              sw_rst_req_o,
  output logic              addr_hi_addr_o
);
  localparam int NGATE = 2;  // 0: wait, 1: stop

  logic ctrl_rst_n;
  logic sel_ctrl, sel_sts, wr_ctrl, wr_sts;
  logic dbg_q, sw_req_q, init_pend_q, addr_hi_q;
  logic [1:0] dis_code [NGATE];
  logic [NGATE-1:0] gate_req, gate_grant;
  rst_cause_t sts, sts_set, sts_clr;

  assign ctrl_rst_n = rst_ni & sys_rst_ni;
  assign sel_ctrl   = (addr_i == ADDR_W'(CTRL_OFS));
  assign sel_sts    = (addr_i == ADDR_W'(STS_OFS));
  assign wr_ctrl    = we_i && sel_ctrl;
  assign wr_sts     = we_i && sel_sts;

  assign gate_req = {stop_req_i, wait_req_i};

  for (genvar g = 0; g < NGATE; g++) begin : g_gate
    sysctl_dis_field u_field (
      .clk_i   (clk_i),
      .rst_ni  (ctrl_rst_n),
      .wr_i    (wr_ctrl),
      .wcode_i (wdata_i[WAIT_LSB+2*g +: 2]),
      .req_i   (gate_req[g]),
      .code_o  (dis_code[g]),
      .grant_o (gate_grant[g])
    );
  end

  assign wait_en_o = gate_grant[0];
  assign stop_en_o = gate_grant[1];

  always_ff @(posedge clk_i or negedge ctrl_rst_n) begin
    if (!ctrl_rst_n) begin
      dbg_q       <= 1'b0;
      sw_req_q    <= 1'b0;
      init_pend_q <= 1'b1;
      addr_hi_q   <= 1'b0;
    end else begin
      sw_req_q <= wr_ctrl && wdata_i[SWR_BIT];
      if (wr_ctrl) dbg_q <= wdata_i[DBG_BIT];
      if (init_pend_q) begin
        addr_hi_q   <= boot_mode_i & ext_boot_i;
        init_pend_q <= 1'b0;
      end
    end
  end

  assign dbg_clk_en_o   = dbg_q | tap_en_i;
  assign sw_rst_req_o   = sw_req_q;
  assign addr_hi_addr_o = addr_hi_q;

  always_comb begin
    sts_set     = '0;
    sts_set.sw  = wr_ctrl && wdata_i[SWR_BIT];
    sts_set.wd  = wdog_rst_evt_i;
    sts_set.ext = ext_rst_evt_i;
    sts_clr     = wr_sts ? rst_cause_t'(wdata_i[STS_LSB +: STS_N]) : '0;
  end

  sysctl_rst_status #(
    .N       (STS_N),
    .POR_VAL (STS_N'(1))
  ) u_sts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (sts_set),
    .clr_i  (sts_clr),
    .sts_o  (sts)
  );

  always_comb begin
    rdata_o = '0;
    if (sel_ctrl) begin
      rdata_o[BOOT_BIT]          = boot_mode_i;
      rdata_o[DBG_BIT]           = dbg_q;
      rdata_o[STOP_LSB +: 2]     = dis_code[1];
      rdata_o[WAIT_LSB +: 2]     = dis_code[0];
    end else if (sel_sts) begin
      rdata_o[STS_LSB +: STS_N]  = sts;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[DATA_W-1:BOOT_BIT]};
endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sys_rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              stop_en_o,
  input logic              wait_en_o,
  input logic              sw_rst_req_o,
  input logic [1:0]        stop_code_i,
  input logic [1:0]        wait_code_i,
  input logic [3:0]        sts_i
);
  a_r2_stop_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_code_i != 2'b00) |-> !stop_en_o);

  a_r4_wait_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_code_i != 2'b00) |-> !wait_en_o);

  a_r3_stop_lock_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni || !sys_rst_ni)
    stop_code_i[1] |=> $stable(stop_code_i));

  a_r4_wait_lock_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni || !sys_rst_ni)
    wait_code_i[1] |=> $stable(wait_code_i));

  a_r5_swr_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(0)) |-> !rdata_o[4]);

  a_r5_swr_pulse_cause: assert property (@(posedge clk_i) disable iff (!rst_ni || !sys_rst_ni)
    sw_rst_req_o |-> $past(we_i && addr_i == ADDR_W'(0) && wdata_i[4]));

  a_r9_sw_cause_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sts_i[3]) |-> $past(we_i && addr_i == ADDR_W'(1) && wdata_i[5]));

  a_r9_wd_cause_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sts_i[2]) |-> $past(we_i && addr_i == ADDR_W'(1) && wdata_i[4]));

  a_r11_sts_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(1)) |-> (rdata_o[DATA_W-1:6] == '0 && rdata_o[1:0] == 2'b00));

  logic unused_chk;
  assign unused_chk = ^{wdata_i, sts_i[1:0]};
endmodule

bind sysctl_regs sysctl_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sys_rst_ni   (sys_rst_ni),
  .addr_i       (addr_i),
  .we_i         (we_i),
  .wdata_i      (wdata_i),
  .rdata_o      (rdata_o),
  .stop_en_o    (stop_en_o),
  .wait_en_o    (wait_en_o),
  .sw_rst_req_o (sw_rst_req_o),
  .stop_code_i  (dis_code[1]),
  .wait_code_i  (dis_code[0]),
  .sts_i        (sts)
);

// File: tb/sysctl_regs_tb.sv
module sysctl_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0, sys_rst_ni = 1'b1;
  logic [ADDR_W-1:0] addr_i = '0;
  logic we_i = 1'b0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic [DATA_W-1:0] rdata_o;
  logic boot_mode_i = 1'b1, ext_boot_i = 1'b1, tap_en_i = 1'b0;
  logic stop_req_i = 1'b0, wait_req_i = 1'b0;
  logic wdog_rst_evt_i = 1'b0, ext_rst_evt_i = 1'b0;
  logic stop_en_o, wait_en_o, dbg_clk_en_o, sw_rst_req_o, addr_hi_addr_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct {
    int          sel;
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sys_rst_ni(sys_rst_ni),
    .addr_i(addr_i), .we_i(we_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .boot_mode_i(boot_mode_i), .ext_boot_i(ext_boot_i), .tap_en_i(tap_en_i),
    .stop_req_i(stop_req_i), .wait_req_i(wait_req_i),
    .wdog_rst_evt_i(wdog_rst_evt_i), .ext_rst_evt_i(ext_rst_evt_i),
    .stop_en_o(stop_en_o), .wait_en_o(wait_en_o), .dbg_clk_en_o(dbg_clk_en_o),
    .sw_rst_req_o(sw_rst_req_o), .addr_hi_addr_o(addr_hi_addr_o)
  );

  // observable selectors
  localparam int O_RD = 0, O_SWR = 1, O_STOP = 2, O_WAIT = 3, O_DBG = 4, O_AHI = 5;

  function automatic logic [15:0] observe(int sel);
    case (sel)
      O_RD:    return rdata_o;
      O_SWR:   return 16'(sw_rst_req_o);
      O_STOP:  return 16'(stop_en_o);
      O_WAIT:  return 16'(wait_en_o);
      O_DBG:   return 16'(dbg_clk_en_o);
      default: return 16'(addr_hi_addr_o);
    endcase
  endfunction

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it  = sb_q.pop_front();
        act = observe(it.sel);
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual=0x%04h expected=0x%04h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expect_v(int sel, logic [ADDR_W-1:0] a, logic [15:0] e, string tag);
    item_t it;
    addr_i = a;
    it.sel = sel; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [15:0] d);
    addr_i = a; we_i = 1'b1; wdata_i = d;
    @(negedge clk);
    we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic sys_rst(logic wd, logic ex);
    sys_rst_ni = 1'b0; wdog_rst_evt_i = wd; ext_rst_evt_i = ex;
    @(negedge clk);
    wdog_rst_evt_i = 1'b0; ext_rst_evt_i = 1'b0;
    @(negedge clk);
    sys_rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL all requirements: watchdog expired, actual=running expected=finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    expect_v(O_AHI, 0, 16'h0001, "R7 address role after power-on, boot=1 ext=1");
    expect_v(O_RD,  0, 16'h0040, "R1 control after power-on");
    expect_v(O_RD,  1, 16'h0004, "R1 cause register after power-on");

    ext_boot_i = 1'b0;
    sys_rst(1'b0, 1'b1);
    expect_v(O_AHI, 0, 16'h0000, "R7 address role, ext boot 0");
    expect_v(O_RD,  1, 16'h000C, "R9 ext cause set, por kept through system reset");
    boot_mode_i = 1'b0;
    expect_v(O_RD,  0, 16'h0000, "R6 live boot pin low");
    boot_mode_i = 1'b1;
    expect_v(O_RD,  0, 16'h0040, "R6 live boot pin high");
    boot_mode_i = 1'b0;

    wr(1, 16'h0004);
    expect_v(O_RD, 1, 16'h0008, "R10 clear por bit");
    wr(1, 16'h0000);
    expect_v(O_RD, 1, 16'h0008, "R10 zero write keeps bits");

    wr(0, 16'h0010);
    expect_v(O_SWR, 0, 16'h0001, "R5 request in cycle after write");
    expect_v(O_SWR, 0, 16'h0000, "R5 request lasts one cycle");
    expect_v(O_RD,  0, 16'h0000, "R5 bit 4 reads zero");
    expect_v(O_RD,  1, 16'h0028, "R5 software cause set");

    wdog_rst_evt_i = 1'b1;
    @(negedge clk);
    wdog_rst_evt_i = 1'b0;
    expect_v(O_RD, 1, 16'h0038, "R9 watchdog cause set");

    addr_i = 1; we_i = 1'b1; wdata_i = 16'h0010; wdog_rst_evt_i = 1'b1;
    @(negedge clk);
    we_i = 1'b0; wdata_i = '0; wdog_rst_evt_i = 1'b0;
    expect_v(O_RD, 1, 16'h0038, "R10 set wins over clear");
    wr(1, 16'h0030);
    expect_v(O_RD, 1, 16'h0008, "R10 clear sw and wdog bits");

    stop_req_i = 1'b1; wait_req_i = 1'b1;
    expect_v(O_STOP, 0, 16'h0001, "R2 code 00 passes stop");
    expect_v(O_WAIT, 0, 16'h0001, "R4 code 00 passes wait");
    wr(0, 16'h0005);
    expect_v(O_RD,   0, 16'h0005, "R2 soft codes written");
    expect_v(O_STOP, 0, 16'h0000, "R2 code 01 blocks stop");
    expect_v(O_WAIT, 0, 16'h0000, "R4 code 01 blocks wait");
    wr(0, 16'h0000);
    expect_v(O_RD,   0, 16'h0000, "R2 code 01 is rewritable");
    expect_v(O_STOP, 0, 16'h0001, "R2 stop passes again");
    wr(0, 16'h0004);
    expect_v(O_STOP, 0, 16'h0000, "R2 stop-only block");
    expect_v(O_WAIT, 0, 16'h0001, "R4 wait independent of stop field");

    wr(0, 16'h002A);
    expect_v(O_RD,  0, 16'h002A, "R3 lock codes written");
    expect_v(O_DBG, 0, 16'h0001, "R8 forced debug clock");
    expect_v(O_STOP,0, 16'h0000, "R3 code 10 blocks stop");
    wr(0, 16'h0000);
    expect_v(O_RD,  0, 16'h000A, "R3 locked fields ignore write, debug bit clears");
    expect_v(O_DBG, 0, 16'h0000, "R8 debug clock off with tap off");
    tap_en_i = 1'b1;
    expect_v(O_DBG, 0, 16'h0001, "R8 debug clock follows tap");
    tap_en_i = 1'b0;
    wr(0, 16'h0020);
    expect_v(O_RD,  0, 16'h002A, "R3 other field writable while locked");
    wr(0, 16'h0005);
    expect_v(O_RD,  0, 16'h000A, "R4 wait lock ignores write");

    boot_mode_i = 1'b1; ext_boot_i = 1'b1;
    sys_rst(1'b1, 1'b0);
    expect_v(O_RD,   0, 16'h0040, "R12 system reset clears locked control");
    expect_v(O_STOP, 0, 16'h0001, "R12 stop passes after system reset");
    expect_v(O_AHI,  0, 16'h0001, "R7 address role recaptured");
    expect_v(O_RD,   1, 16'h0018, "R9 wdog cause added, history kept");
    boot_mode_i = 1'b0;

    wr(0, 16'h000F);
    expect_v(O_RD,   0, 16'h000F, "R3 code 11 written");
    wr(0, 16'h0000);
    expect_v(O_RD,   0, 16'h000F, "R3 code 11 also locks");
    expect_v(O_WAIT, 0, 16'h0000, "R4 code 11 blocks wait");

    wr(2, 16'hFFFF);
    expect_v(O_RD, 2, 16'h0000, "R11 unmapped offset 2 reads zero");
    expect_v(O_RD, 3, 16'h0000, "R11 unmapped offset 3 reads zero");
    expect_v(O_RD, 0, 16'h000F, "R11 control unchanged by unmapped write");
    expect_v(O_RD, 1, 16'h0018, "R11 causes unchanged by unmapped write");
    expect_v(O_SWR, 0, 16'h0000, "R11 no request from unmapped write");

    @(negedge clk);
    done = 1'b1;
    summary();
  end
endmodule